// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software through a 7-bit down-counter. The counter is ticked from the peripheral clock through a base divider and a 2-bit selectable prescaler. Software must reload the counter at intervals. A reload counts as valid only inside a window: the counter must be at or below a programmable upper limit and above 0x3F. If the counter is allowed to drop from 0x40 to 0x3F while the watchdog is armed, the block raises a reset request. It does the same if software reloads too early, or if software writes the control register with bit 6 of the counter clear while the watchdog is armed or being armed. An optional early-warning interrupt fires when the counter steps down to 0x40, which gives service code one last chance to reload.

Three registers sit behind a simple write strobe and a separate read selector. A reset request is a pulse of a fixed number of clock cycles. For the whole pulse every register inside the block is held at its reset value, just as a system reset would hold it. The prescaler phase is not cleared by a reload, so the first tick after a reload may come early or late.

Top module: `winwd_top`

## Requirements
- R1: After reset, and during every reset request, the registers read: control selector 0 gives 0x07F (enable 0, counter 0x7F); configuration selector 1 gives 0x07F (warning enable 0, prescaler 0, window 0x7F); status selector 2 gives 0. `rst_req` and `irq` are low.
- R2: The counter decrements by one every BASE_DIV × 2^P clock cycles, where P is configuration bits [8:7]. It keeps counting while the watchdog is disarmed, and passing 0x3F while disarmed causes no reset request.
- R3: Writing the control register (selector 0) with bit 7 set arms the watchdog. A later control write with bit 7 clear leaves it armed. Only a reset clears it.
- R4: While the watchdog is armed, a tick that moves the counter from 0x40 to 0x3F raises a reset request from that clock edge, unless a control write happens on the same edge.
- R5: While the watchdog is armed, a control write at a clock edge where the counter is greater than the window (configuration bits [6:0]) raises a reset request. A counter equal to the window is accepted.
- R6: A control write with bit 6 clear raises an immediate reset request if bit 7 of the written data is set or the watchdog is already armed. With both clear, it only loads the counter.
- R7: A reset request holds `rst_req` high for exactly RST_PULSE cycles, starting at the clock edge of the fault. Writes made during the pulse are ignored.
- R8: When configuration bit 9 is set, the tick that moves the counter from 0x41 to 0x40 sets the warning flag (status bit 0), and `irq` follows the flag.
- R9: Writing status with bit 0 clear clears the flag. Writing it with bit 0 set has no effect. The flag is not set again while the counter stays below 0x40.
- R10: A control write that raises no fault loads the counter with data bits [6:0]. A load on the same edge as a tick takes priority over the decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 configuration, 2 status |
| wr_data | input | 10 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 10 | Combinational read data of the selected register |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Early-warning interrupt |

## Verification
A write, and any fault it causes, takes effect on the clock edge where the strobe is sampled. That means the loaded counter, the armed bit and a high `rst_req` are all visible at the falling edge that follows, and `rst_req` stays high for RST_PULSE falling edges. The counter moves once per divided period, so a change seen at one falling edge is followed by the next change exactly BASE_DIV × 2^P falling edges later. The bench polls the counter readback at falling edges until it sees the target value, then drives the write in that same half cycle. This makes the window comparison see exactly the polled value, and independent of prescaler phase. The warning flag is checked at the falling edge where the counter first reads 0x40.

// File: rtl/winwd_pkg.sv
package winwd_pkg;

    localparam int CNT_W  = 7;
    localparam int DATA_W = 10;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    // configuration register: [9] warning enable, [8:7] prescaler, [6:0] window
    typedef struct packed {
        logic       ew_en;
        logic [1:0] div_sel;
        cnt_t       win;
    } cfg_t;

    // control register: [7] arm, [6:0] counter
    typedef struct packed {
        logic en;
        cnt_t val;
    } ctrl_t;

    localparam cnt_t CNT_RST  = 7'h7F;
    localparam cnt_t WARN_VAL = 7'h40;
    localparam cfg_t CFG_RST  = '{ew_en: 1'b0, div_sel: 2'b00, win: 7'h7F};

    function automatic logic msb_clear(input ctrl_t w);
        return !w.val[CNT_W-1];
    endfunction

endpackage

// File: rtl/winwd_prescaler.sv
module winwd_prescaler #(
    parameter int BASE_DIV = 4096,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int PW      = $clog2(MAX_DIV) + 1;

    logic [PW-1:0] presc_q;
    logic [PW-1:0] lim;

    assign lim  = PW'(BASE_DIV) << div_sel;
    assign tick = (presc_q >= lim - PW'(1));

    always_ff @(posedge clk) begin
        if (clr)       presc_q <= '0;
        else if (tick) presc_q <= '0;
        else           presc_q <= presc_q + PW'(1);
    end

endmodule

// File: rtl/winwd_counter.sv
module winwd_counter
    import winwd_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  logic load,
    input  cnt_t load_val,
    input  logic ew_en,
    input  logic flag_clr,
    output cnt_t cnt,
    output logic flag
);
    cnt_t cnt_q;
    logic flag_q;
    logic warn_hit;

    assign warn_hit = tick && !load && ew_en && (cnt_q == WARN_VAL + 7'd1);

    always_ff @(posedge clk) begin
        if (clr)       cnt_q <= CNT_RST;
        else if (load) cnt_q <= load_val;
        else if (tick) cnt_q <= cnt_q - 7'd1;
    end

    always_ff @(posedge clk) begin
        if (clr)           flag_q <= 1'b0;
        else if (warn_hit) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (clr)
        (tick && !load) |=> (cnt_q == $past(cnt_q) - 7'd1));

    // R10
    load_value_chk: assert property (@(posedge clk) disable iff (clr)
        load |=> (cnt_q == $past(load_val)));

    // R8
    flag_origin_chk: assert property (@(posedge clk) disable iff (clr)
        $rose(flag_q) |-> ($past(cnt_q) == WARN_VAL + 7'd1));

endmodule

// File: rtl/winwd_fault.sv
module winwd_fault #(
    parameter int RST_PULSE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    output logic rst_req
);
    localparam int PCW = $clog2(RST_PULSE + 1);

    logic [PCW-1:0] pulse_q;

    always_ff @(posedge clk) begin
        if (rst)                 pulse_q <= '0;
        else if (fault)          pulse_q <= PCW'(RST_PULSE);
        else if (pulse_q != '0)  pulse_q <= pulse_q - PCW'(1);
    end

    assign rst_req = (pulse_q != '0);

    // R7
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> rst_req);

    // R7
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req && !fault) |=> (pulse_q < $past(pulse_q)));

endmodule

// File: rtl/winwd_top.sv
module winwd_top
    import winwd_pkg::*;
#(
    parameter int BASE_DIV  = 4096,
    parameter int RST_PULSE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [9:0]  wr_data,
    input  logic [1:0]  rd_sel,
    output logic [9:0]  rd_data,
    output logic        rst_req,
    output logic        irq
);
    ctrl_t wdat;
    cfg_t  cfg_q;
    logic  en_q;
    cnt_t  cnt;
    logic  flag;
    logic  tick;
    logic  ctrl_wr, cfg_wr, stat_clr;
    logic  wr_fault, uf_fault, fault, clr;

    assign wdat     = ctrl_t'(wr_data[7:0]);
    assign ctrl_wr  = wr_en && !rst_req && (wr_sel == SEL_CTRL);
    assign cfg_wr   = wr_en && !rst_req && (wr_sel == SEL_CFG);
    assign stat_clr = wr_en && !rst_req && (wr_sel == SEL_STAT) && !wr_data[0];

    assign wr_fault = ctrl_wr && (((en_q || wdat.en) && msb_clear(wdat))
                                  || (en_q && (cnt > cfg_q.win)));
    assign uf_fault = en_q && tick && !ctrl_wr && (cnt == WARN_VAL);
    assign fault    = wr_fault || uf_fault;
    assign clr      = rst || rst_req || fault;

    always_ff @(posedge clk) begin
        if (clr)                     en_q <= 1'b0;
        else if (ctrl_wr && wdat.en) en_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr)         cfg_q <= CFG_RST;
        else if (cfg_wr) cfg_q <= cfg_t'(wr_data);
    end

    winwd_prescaler #(.BASE_DIV(BASE_DIV), .SEL_W(2)) u_presc (
        .clk     (clk),
        .clr     (clr),
        .div_sel (cfg_q.div_sel),
        .tick    (tick)
    );

    winwd_counter u_cnt (
        .clk      (clk),
        .clr      (clr),
        .tick     (tick),
        .load     (ctrl_wr),
        .load_val (wdat.val),
        .ew_en    (cfg_q.ew_en),
        .flag_clr (stat_clr),
        .cnt      (cnt),
        .flag     (flag)
    );

    winwd_fault #(.RST_PULSE(RST_PULSE)) u_fault (
        .clk     (clk),
        .rst     (rst),
        .fault   (fault),
        .rst_req (rst_req)
    );

    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = {2'b00, en_q, cnt};
            SEL_CFG:  rd_data = cfg_q;
            SEL_STAT: rd_data = {9'd0, flag};
            default:  rd_data = '0;
        endcase
    end

    assign irq = flag;

    // R3
    arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && !rst_req && !fault) |=> en_q);

    // R4
    underflow_req_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && tick && !ctrl_wr && cnt == WARN_VAL) |=> rst_req);

    // R5
    early_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && en_q && cnt > cfg_q.win) |=> rst_req);

    // R1
    held_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fault) |-> (!en_q && cnt == CNT_RST && !flag));

endmodule

// File: tb/tb_winwd_top.sv
module tb_winwd_top;
    localparam int CLK_PERIOD = 10;
    localparam int BDIV       = 4;
    localparam int PULSE      = 4;
    localparam int NV         = 6;

    localparam logic [6:0] TV_WIN  [NV] = '{7'h60, 7'h60, 7'h60, 7'h7F, 7'h50, 7'h7F};
    localparam logic [6:0] TV_AT   [NV] = '{7'h50, 7'h60, 7'h61, 7'h41, 7'h70, 7'h55};
    localparam logic [7:0] TV_DATA [NV] = '{8'hFF, 8'hE0, 8'hFF, 8'hC5, 8'hF0, 8'hBF};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [9:0] wr_data = '0;
    logic [1:0] rd_sel = 2'd0;
    logic [9:0] rd_data;
    logic       rst_req, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    winwd_top #(.BASE_DIV(BDIV), .RST_PULSE(PULSE)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [9:0] d);
        wr_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; #1;
    endtask

    task automatic rd(input logic [1:0] s, output logic [9:0] v);
        rd_sel = s; #1; v = rd_data;
    endtask

    task automatic wait_cnt(input logic [6:0] t, input int lim, output int n);
        rd_sel = 2'd0; #1; n = 0;
        while (rd_data[6:0] != t && n < lim) begin
            @(negedge clk); #1; n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] v;
        int n;
        int hi;
        logic exp_f;
        logic [6:0] prev;

        // R1 reset state
        do_reset();
        rd(2'd0, v); chk("R1 ctrl after reset", v, 10'h07F);
        rd(2'd1, v); chk("R1 cfg after reset", v, 10'h07F);
        rd(2'd2, v); chk("R1 status after reset", v, 10'h000);
        chk("R1 rst_req after reset", {9'd0, rst_req}, 10'd0);
        chk("R1 irq after reset", {9'd0, irq}, 10'd0);

        // window table: R5 R6 R10 R7
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(2'd1, {3'b000, TV_WIN[i]});
            wr(2'd0, 10'h0FF);
            wait_cnt(TV_AT[i], 2000, n);
            chk("R5 reached target", {3'd0, rd_data[6:0]}, {3'd0, TV_AT[i]});
            exp_f = (TV_AT[i] > TV_WIN[i]) || !TV_DATA[i][6];
            wr(2'd0, {2'b00, TV_DATA[i]});
            chk("R5 R6 reload fault", {9'd0, rst_req}, {9'd0, exp_f});
            rd(2'd0, v);
            if (exp_f) chk("R1 registers held during request", v, 10'h07F);
            else       chk("R10 reload value", v, {2'b00, 1'b1, TV_DATA[i][6:0]});
            if (exp_f) begin
                hi = 1;
                for (int k = 0; k < PULSE + 2; k++) begin
                    @(negedge clk); #1;
                    if (rst_req) hi++;
                end
                chk("R7 pulse length", 10'(hi), 10'(PULSE));
            end
        end

        // R3 arm is sticky
        do_reset();
        wr(2'd0, 10'h0FF);
        wr(2'd0, 10'h07F);
        rd(2'd0, v);
        chk("R3 arm ignores clear", v, 10'h0FF);
        chk("R3 no request", {9'd0, rst_req}, 10'd0);

        // R6 software reset and disarmed plain load
        do_reset();
        wr(2'd0, 10'h020);
        rd(2'd0, v);
        chk("R6 disarmed T6-clear load", v, 10'h020);
        chk("R6 no request disarmed", {9'd0, rst_req}, 10'd0);
        do_reset();
        wr(2'd0, 10'h0A0);
        chk("R6 software reset", {9'd0, rst_req}, 10'd1);

        // R4 underflow
        do_reset();
        wr(2'd0, 10'h0C3);
        wait_cnt(7'h40, 200, n);
        chk("R4 no request at 0x40", {9'd0, rst_req}, 10'd0);
        prev = rd_data[6:0];
        n = 0;
        while (!rst_req && n < 20) begin
            prev = rd_data[6:0];
            @(negedge clk); #1; n++;
        end
        chk("R4 request on underflow", {9'd0, rst_req}, 10'd1);
        chk("R4 counter before request", {3'd0, prev}, 10'h040);
        chk("R4 cycles to underflow", 10'(n), 10'(BDIV));

        // R2 free-running while disarmed, no request
        do_reset();
        wait_cnt(7'h3E, 400, n);
        chk("R2 disarmed counter passes 0x3F", {3'd0, rd_data[6:0]}, 10'h03E);
        chk("R2 disarmed no request", {9'd0, rst_req}, 10'd0);

        // R2 prescaler periods
        for (int d = 0; d < 4; d += 3) begin
            do_reset();
            wr(2'd1, {1'b0, 2'(d), 7'h7F});
            wait_cnt(7'h7D, 400, n);
            wait_cnt(7'h7C, 400, n);
            chk("R2 tick period", 10'(n), 10'(BDIV << d));
        end

        // R8 R9 early warning
        do_reset();
        wr(2'd1, 10'h27F);
        wait_cnt(7'h41, 400, n);
        chk("R8 irq low at 0x41", {9'd0, irq}, 10'd0);
        wait_cnt(7'h40, 400, n);
        chk("R8 irq at 0x40", {9'd0, irq}, 10'd1);
        rd(2'd2, v); chk("R8 status flag", v, 10'h001);
        wr(2'd2, 10'h001);
        chk("R9 write 1 no effect", {9'd0, irq}, 10'd1);
        wr(2'd2, 10'h000);
        chk("R9 write 0 clears", {9'd0, irq}, 10'd0);
        wait_cnt(7'h3C, 400, n);
        chk("R9 not set again", {9'd0, irq}, 10'd0);

        do_reset();
        wait_cnt(7'h3F, 400, n);
        chk("R8 no flag when disabled", {9'd0, irq}, 10'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule